// File: doc/BRIEF.md
# 9/7 Lifting Forward Wavelet Pipeline

This block computes a one-dimensional forward discrete wavelet transform with the 9/7 biorthogonal filter. It uses four lifting steps followed by a scaling step. Samples arrive as pairs. Each beat carries the even sample x[2n] and the odd sample x[2n+1] that follows it. For every accepted pair, the block returns one low-pass coefficient and one high-pass coefficient. A start-of-line flag and an end-of-line flag travel with the data. Each lifting stage uses them to mirror the signal at the line edges, so no extra beats are inserted.

The steps run in a fixed order: predict, update, predict, update. Each step adds a coefficient times the sum of the two neighbours of opposite parity. Between the stages, all data flows forward through registers, so each clock period holds only one multiply-add. The predict stages hold one pair back to see the next even sample. The update stages keep the previous odd result. A continuous line therefore leaves at one pair per clock. Idle beats may appear anywhere in the input.

Top module: `dwt97_fwd_lift`

## Requirements
- R1: While reset is low, and on the first cycles after it is released, `out_vld_o` is 0.
- R2: With d1[n]=x[2n+1]+a(x[2n]+x[2n+2]), s1[n]=x[2n]+b(d1[n-1]+d1[n]), d2[n]=d1[n]+g(s1[n]+s1[n+1]) and s2[n]=s1[n]+h(d2[n-1]+d2[n]), the low output is z*s2[n]. The constants are a=-1.586134342, b=-0.05298011854, g=0.8829110762, h=0.4435068522 and z=1.149604398. The result is within 2 LSB for inputs in the range ±8000.
- R3: The high output equals d2[n]/z, within 2 LSB under the same conditions.
- R4: On the pair flagged start-of-line, each missing left neighbour is the mirror of its right neighbour: d1[-1]=d1[0] and d2[-1]=d2[0].
- R5: On the pair flagged end-of-line, each missing right neighbour is the mirror of its left neighbour: x[2M]=x[2M-2] and s1[M]=s1[M-1].
- R6: A line of a single pair, with both flags set, uses both mirrors: the low output is z*s2[0] and the high output is d2[0]/z.
- R7: Every accepted pair yields exactly one output, in input order. Its start-of-line and end-of-line flags repeat those of the input pair. Flags are never high without `out_vld_o`.
- R8: Lines sent back to back, with a start-of-line pair in the cycle right after an end-of-line pair, are transformed independently of each other.
- R9: For a line sent without idle beats, the output of its last pair comes exactly M-1 cycles after the output of its first pair. That is one pair per clock.
- R10: Cycles with `in_vld_i` low are ignored, whatever is on the data and flag inputs. A line broken by idle beats gives the same coefficients as the same line sent without them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_vld_i | input | 1 | Input pair valid |
| in_sol_i | input | 1 | Pair is the first of a line (active high) |
| in_eol_i | input | 1 | Pair is the last of a line (active high) |
| in_even_i | input | DW | Even sample x[2n], signed |
| in_odd_i | input | DW | Odd sample x[2n+1], signed |
| out_vld_o | output | 1 | Output coefficient pair valid |
| out_sol_o | output | 1 | Coefficients belong to the first pair of a line |
| out_eol_o | output | 1 | Coefficients belong to the last pair of a line |
| out_low_o | output | OW | Low-pass coefficient, signed |
| out_high_o | output | OW | High-pass coefficient, signed |

## Verification
The hardest case is the end-of-line pair sitting in a predict stage's hold register while the start-of-line pair of the next line is already arriving. In that case the mirror has to win over the fresh neighbour, and the hold register has to be reloaded in the same cycle. The stimulus reaches this case by sending lines back to back, including a one-pair line between two longer ones. It also sends lines broken by idle beats that carry random data and random flags. This keeps the hold register waiting across gaps, while a behavioural double-precision model checks every output.

// File: rtl/dwt97_pkg.sv
package dwt97_pkg;

  localparam real LIFT_A = -1.586134342;
  localparam real LIFT_B = -0.05298011854;
  localparam real LIFT_G = 0.8829110762;
  localparam real LIFT_H = 0.4435068522;
  localparam real SCALE_Z = 1.149604398;

  // round-to-nearest fixed-point constant
  function automatic int quant(real r, int fb);
    return int'($floor(r * (2.0 ** fb) + 0.5));
  endfunction

  function automatic real lift_coef(int k);
    case (k)
      0:       return LIFT_A;
      1:       return LIFT_B;
      2:       return LIFT_G;
      default: return LIFT_H;
    endcase
  endfunction

endpackage

// File: rtl/dwt97_mac.sv
module dwt97_mac #(
  parameter int IW   = 24,
  parameter int CW   = 16,
  parameter int CF   = 14,
  parameter int COEF = 0
) (
  input  logic signed [IW-1:0] base_i,
  input  logic signed [IW-1:0] left_i,
  input  logic signed [IW-1:0] right_i,
  output logic signed [IW-1:0] res_o
);
  localparam int PW = IW + 1 + CW;
  localparam logic signed [CW-1:0] COEF_C = CW'(COEF);
  localparam logic signed [PW-1:0] HALF = PW'(1) << (CF - 1);

  logic signed [IW:0]   pair_sum;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] rnd;
  logic signed [PW-1:0] scl;
  logic                 unused_hi;

  always_comb begin
    pair_sum = (IW+1)'(left_i) + (IW+1)'(right_i);
    prod     = PW'(pair_sum) * PW'(COEF_C);
    rnd      = prod + HALF;
    scl      = rnd >>> CF;
    res_o    = base_i + scl[IW-1:0];
  end

  assign unused_hi = ^scl[PW-1:IW];
endmodule

// File: rtl/dwt97_predict_stage.sv
module dwt97_predict_stage #(
  parameter int IW   = 24,
  parameter int CW   = 16,
  parameter int CF   = 14,
  parameter int COEF = 0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_vld_i,
  input  logic                 in_sol_i,
  input  logic                 in_eol_i,
  input  logic signed [IW-1:0] in_ev_i,
  input  logic signed [IW-1:0] in_od_i,
  output logic                 out_vld_o,
  output logic                 out_sol_o,
  output logic                 out_eol_o,
  output logic signed [IW-1:0] out_ev_o,
  output logic signed [IW-1:0] out_od_o
);
  logic                 h_vld, h_sol, h_eol;
  logic signed [IW-1:0] h_ev, h_od;
  logic                 fire;
  logic signed [IW-1:0] nb_ev;
  logic signed [IW-1:0] mac_res;

  // held pair leaves once its right neighbour is known (next pair or mirror)
  assign fire  = h_vld && (h_eol || in_vld_i);
  assign nb_ev = h_eol ? h_ev : in_ev_i;

  dwt97_mac #(.IW(IW), .CW(CW), .CF(CF), .COEF(COEF)) u_mac (
    .base_i (h_od),
    .left_i (h_ev),
    .right_i(nb_ev),
    .res_o  (mac_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_vld     <= 1'b0;
      h_sol     <= 1'b0;
      h_eol     <= 1'b0;
      h_ev      <= '0;
      h_od      <= '0;
      out_vld_o <= 1'b0;
      out_sol_o <= 1'b0;
      out_eol_o <= 1'b0;
      out_ev_o  <= '0;
      out_od_o  <= '0;
    end else begin
      out_vld_o <= fire;
      out_sol_o <= fire & h_sol;
      out_eol_o <= fire & h_eol;
      if (fire) begin
        out_ev_o <= h_ev;
        out_od_o <= mac_res;
      end
      if (in_vld_i) begin
        h_vld <= 1'b1;
        h_sol <= in_sol_i;
        h_eol <= in_eol_i;
        h_ev  <= in_ev_i;
        h_od  <= in_od_i;
      end else if (fire) begin
        h_vld <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dwt97_update_stage.sv
module dwt97_update_stage #(
  parameter int IW   = 24,
  parameter int CW   = 16,
  parameter int CF   = 14,
  parameter int COEF = 0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_vld_i,
  input  logic                 in_sol_i,
  input  logic                 in_eol_i,
  input  logic signed [IW-1:0] in_ev_i,
  input  logic signed [IW-1:0] in_od_i,
  output logic                 out_vld_o,
  output logic                 out_sol_o,
  output logic                 out_eol_o,
  output logic signed [IW-1:0] out_ev_o,
  output logic signed [IW-1:0] out_od_o
);
  logic signed [IW-1:0] last_od;
  logic signed [IW-1:0] prev_od;
  logic signed [IW-1:0] mac_res;

  // left mirror at line start
  assign prev_od = in_sol_i ? in_od_i : last_od;

  dwt97_mac #(.IW(IW), .CW(CW), .CF(CF), .COEF(COEF)) u_mac (
    .base_i (in_ev_i),
    .left_i (prev_od),
    .right_i(in_od_i),
    .res_o  (mac_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_od   <= '0;
      out_vld_o <= 1'b0;
      out_sol_o <= 1'b0;
      out_eol_o <= 1'b0;
      out_ev_o  <= '0;
      out_od_o  <= '0;
    end else begin
      out_vld_o <= in_vld_i;
      out_sol_o <= in_vld_i & in_sol_i;
      out_eol_o <= in_vld_i & in_eol_i;
      if (in_vld_i) begin
        out_ev_o <= mac_res;
        out_od_o <= in_od_i;
        last_od  <= in_od_i;
      end
    end
  end
endmodule

// File: rtl/dwt97_scale_stage.sv
module dwt97_scale_stage #(
  parameter int IW  = 24,
  parameter int OW  = 18,
  parameter int CW  = 16,
  parameter int CF  = 14,
  parameter int GF  = 4,
  parameter int KLO = 0,
  parameter int KHI = 0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_vld_i,
  input  logic                 in_sol_i,
  input  logic                 in_eol_i,
  input  logic signed [IW-1:0] in_ev_i,
  input  logic signed [IW-1:0] in_od_i,
  output logic                 out_vld_o,
  output logic                 out_sol_o,
  output logic                 out_eol_o,
  output logic signed [OW-1:0] out_low_o,
  output logic signed [OW-1:0] out_high_o
);
  localparam int PW = IW + CW;
  localparam int SH = CF + GF;
  localparam logic signed [CW-1:0] KLO_C = CW'(KLO);
  localparam logic signed [CW-1:0] KHI_C = CW'(KHI);
  localparam logic signed [PW-1:0] HALF  = PW'(1) << (SH - 1);

  logic signed [PW-1:0] lo_sh, hi_sh;
  logic                 unused_bits;

  // scale and drop guard bits with one rounding
  always_comb begin
    lo_sh = ((PW'(in_ev_i) * PW'(KLO_C)) + HALF) >>> SH;
    hi_sh = ((PW'(in_od_i) * PW'(KHI_C)) + HALF) >>> SH;
  end

  assign unused_bits = ^{lo_sh[PW-1:OW], hi_sh[PW-1:OW]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_vld_o  <= 1'b0;
      out_sol_o  <= 1'b0;
      out_eol_o  <= 1'b0;
      out_low_o  <= '0;
      out_high_o <= '0;
    end else begin
      out_vld_o <= in_vld_i;
      out_sol_o <= in_vld_i & in_sol_i;
      out_eol_o <= in_vld_i & in_eol_i;
      if (in_vld_i) begin
        out_low_o  <= lo_sh[OW-1:0];
        out_high_o <= hi_sh[OW-1:0];
      end
    end
  end
endmodule

// File: rtl/dwt97_fwd_lift.sv
module dwt97_fwd_lift #(
  parameter int DW = 16,
  parameter int OW = DW + 2,
  parameter int CF = 14,
  parameter int GF = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_vld_i,
  input  logic                 in_sol_i,
  input  logic                 in_eol_i,
  input  logic signed [DW-1:0] in_even_i,
  input  logic signed [DW-1:0] in_odd_i,
  output logic                 out_vld_o,
  output logic                 out_sol_o,
  output logic                 out_eol_o,
  output logic signed [OW-1:0] out_low_o,
  output logic signed [OW-1:0] out_high_o
);
  import dwt97_pkg::*;

  localparam int NSTEP = 4;
  localparam int IW    = DW + GF + 4;
  localparam int CW    = CF + 2;
  localparam int KLO   = quant(SCALE_Z, CF);
  localparam int KHI   = quant(1.0 / SCALE_Z, CF);

  logic [NSTEP:0]       vld_s, sol_s, eol_s;
  logic signed [IW-1:0] ev_s [NSTEP+1];
  logic signed [IW-1:0] od_s [NSTEP+1];

  assign vld_s[0] = in_vld_i;
  assign sol_s[0] = in_sol_i;
  assign eol_s[0] = in_eol_i;
  assign ev_s[0]  = IW'(in_even_i) <<< GF;
  assign od_s[0]  = IW'(in_odd_i) <<< GF;

  for (genvar k = 0; k < NSTEP; k++) begin : g_step
    localparam int QK = quant(lift_coef(k), CF);
    if (k % 2 == 0) begin : g_pred
      dwt97_predict_stage #(.IW(IW), .CW(CW), .CF(CF), .COEF(QK)) u_stage (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .in_vld_i (vld_s[k]),
        .in_sol_i (sol_s[k]),
        .in_eol_i (eol_s[k]),
        .in_ev_i  (ev_s[k]),
        .in_od_i  (od_s[k]),
        .out_vld_o(vld_s[k+1]),
        .out_sol_o(sol_s[k+1]),
        .out_eol_o(eol_s[k+1]),
        .out_ev_o (ev_s[k+1]),
        .out_od_o (od_s[k+1])
      );
    end else begin : g_upd
      dwt97_update_stage #(.IW(IW), .CW(CW), .CF(CF), .COEF(QK)) u_stage (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .in_vld_i (vld_s[k]),
        .in_sol_i (sol_s[k]),
        .in_eol_i (eol_s[k]),
        .in_ev_i  (ev_s[k]),
        .in_od_i  (od_s[k]),
        .out_vld_o(vld_s[k+1]),
        .out_sol_o(sol_s[k+1]),
        .out_eol_o(eol_s[k+1]),
        .out_ev_o (ev_s[k+1]),
        .out_od_o (od_s[k+1])
      );
    end
  end

  dwt97_scale_stage #(
    .IW(IW), .OW(OW), .CW(CW), .CF(CF), .GF(GF), .KLO(KLO), .KHI(KHI)
  ) u_scale (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .in_vld_i  (vld_s[NSTEP]),
    .in_sol_i  (sol_s[NSTEP]),
    .in_eol_i  (eol_s[NSTEP]),
    .in_ev_i   (ev_s[NSTEP]),
    .in_od_i   (od_s[NSTEP]),
    .out_vld_o (out_vld_o),
    .out_sol_o (out_sol_o),
    .out_eol_o (out_eol_o),
    .out_low_o (out_low_o),
    .out_high_o(out_high_o)
  );
endmodule

// File: rtl/dwt97_fwd_lift_chk.sv
module dwt97_fwd_lift_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic in_vld_i,
  input logic out_vld_o,
  input logic out_sol_o,
  input logic out_eol_o
);
  localparam int MAX_PEND = 7;

  logic [3:0] pending;
  logic       line_open;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending   <= '0;
      line_open <= 1'b0;
    end else begin
      pending <= pending + 4'(in_vld_i) - 4'(out_vld_o);
      if (out_vld_o) line_open <= !out_eol_o;
    end
  end

  p_flags_need_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_sol_o || out_eol_o) |-> out_vld_o);

  p_no_spurious_out_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o |-> (pending != 4'd0));

  p_bounded_inflight_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending <= 4'(MAX_PEND));

  p_line_opens_with_sol_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_vld_o && !line_open) |-> out_sol_o);

  p_no_sol_inside_line_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_vld_o && line_open) |-> !out_sol_o);
endmodule

bind dwt97_fwd_lift dwt97_fwd_lift_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .in_vld_i (in_vld_i),
  .out_vld_o(out_vld_o),
  .out_sol_o(out_sol_o),
  .out_eol_o(out_eol_o)
);

// File: tb/test_dwt97_fwd_lift.sv
module test_dwt97_fwd_lift;
  localparam int DW = 16;
  localparam int OW = 18;
  localparam real A = -1.586134342;
  localparam real B = -0.05298011854;
  localparam real G = 0.8829110762;
  localparam real H = 0.4435068522;
  localparam real Z = 1.149604398;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic in_vld_i = 1'b0, in_sol_i = 1'b0, in_eol_i = 1'b0;
  logic signed [DW-1:0] in_even_i = '0, in_odd_i = '0;
  logic out_vld_o, out_sol_o, out_eol_o;
  logic signed [OW-1:0] out_low_o, out_high_o;

  always #5 clk = ~clk;

  dwt97_fwd_lift #(.DW(DW), .OW(OW)) i_dwt97_fwd_lift (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_vld_i(in_vld_i), .in_sol_i(in_sol_i), .in_eol_i(in_eol_i),
    .in_even_i(in_even_i), .in_odd_i(in_odd_i),
    .out_vld_o(out_vld_o), .out_sol_o(out_sol_o), .out_eol_o(out_eol_o),
    .out_low_o(out_low_o), .out_high_o(out_high_o)
  );

  int checks = 0, bad = 0;
  bit done = 1'b0;
  int cyc = 0;
  real q_lo[$], q_hi[$];
  bit q_sol[$], q_eol[$];
  string q_tlo[$], q_thi[$];
  int l_len[$];
  bit l_contig[$];
  int sol_cyc = 0, cur_len = 0;
  bit cur_contig = 1'b0;

  always @(posedge clk) cyc++;

  task automatic chk_num(string tag, real act, real exp);
    checks++;
    if (act - exp > 2.0 || exp - act > 2.0) begin
      bad++;
      $display("FAIL %s act=%0.3f exp=%0.3f", tag, act, exp);
    end
  endtask

  task automatic chk_bit(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // output monitor, away from the active edge
  always @(negedge clk) begin
    if (rst_ni && out_vld_o) begin
      if (q_lo.size() == 0) begin
        chk_bit("R7 unexpected output", 1, 0);
      end else begin
        chk_num(q_tlo[0], real'(out_low_o), q_lo[0]);
        chk_num(q_thi[0], real'(out_high_o), q_hi[0]);
        chk_bit("R7 sol flag", int'(out_sol_o), int'(q_sol[0]));
        chk_bit("R7 eol flag", int'(out_eol_o), int'(q_eol[0]));
        void'(q_lo.pop_front()); void'(q_hi.pop_front());
        void'(q_sol.pop_front()); void'(q_eol.pop_front());
        void'(q_tlo.pop_front()); void'(q_thi.pop_front());
      end
      if (out_sol_o && l_len.size() > 0) begin
        sol_cyc = cyc;
        cur_len = l_len.pop_front();
        cur_contig = l_contig.pop_front();
      end
      if (out_eol_o && cur_contig) chk_bit("R9 line span cycles", cyc - sol_cyc, cur_len - 1);
    end
  end

  task automatic idle(int n, bit garbage);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_vld_i = 1'b0;
      if (garbage) begin
        in_sol_i = 1'($urandom); in_eol_i = 1'($urandom);
        in_even_i = DW'($urandom); in_odd_i = DW'($urandom);
      end
    end
  endtask

  task automatic run_line(int len, int pat, bit gaps, string tag);
    int e[], o[];
    real d1[], s1[], d2[], s2[];
    e = new[len]; o = new[len];
    d1 = new[len]; s1 = new[len]; d2 = new[len]; s2 = new[len];
    for (int n = 0; n < len; n++) begin
      case (pat)
        0: begin e[n] = 1234; o[n] = 1234; end
        1: begin e[n] = 2*n*37 - 3000; o[n] = (2*n+1)*37 - 3000; end
        2: begin e[n] = 5000; o[n] = -5000; end
        default: begin
          e[n] = int'($urandom_range(16000)) - 8000;
          o[n] = int'($urandom_range(16000)) - 8000;
        end
      endcase
    end
    for (int n = 0; n < len; n++)
      d1[n] = o[n] + A * (e[n] + ((n == len-1) ? e[n] : e[n+1]));
    for (int n = 0; n < len; n++)
      s1[n] = e[n] + B * (((n == 0) ? d1[n] : d1[n-1]) + d1[n]);
    for (int n = 0; n < len; n++)
      d2[n] = d1[n] + G * (s1[n] + ((n == len-1) ? s1[n] : s1[n+1]));
    for (int n = 0; n < len; n++)
      s2[n] = s1[n] + H * (((n == 0) ? d2[n] : d2[n-1]) + d2[n]);
    for (int n = 0; n < len; n++) begin
      string tl, th;
      if (tag != "") begin tl = {tag, " low"}; th = {tag, " high"}; end
      else if (len == 1) begin tl = "R6 low"; th = "R6 high"; end
      else if (n == 0) begin tl = "R4 low"; th = "R4 high"; end
      else if (n == len-1) begin tl = "R5 low"; th = "R5 high"; end
      else begin tl = "R2 low"; th = "R3 high"; end
      q_lo.push_back(Z * s2[n]);
      q_hi.push_back(d2[n] / Z);
      q_sol.push_back(n == 0);
      q_eol.push_back(n == len-1);
      q_tlo.push_back(tl); q_thi.push_back(th);
    end
    l_len.push_back(len);
    l_contig.push_back(!gaps);
    for (int n = 0; n < len; n++) begin
      if (gaps) idle(int'($urandom_range(3)), 1'b1);
      @(posedge clk); #1;
      in_vld_i = 1'b1;
      in_sol_i = (n == 0);
      in_eol_i = (n == len-1);
      in_even_i = DW'(e[n]);
      in_odd_i = DW'(o[n]);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_bit("R1 valid during reset", int'(out_vld_o), 0);
    #1 rst_ni = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk_bit("R1 valid after reset", int'(out_vld_o), 0);
    end
    run_line(8, 0, 1'b0, "");  idle(10, 1'b0);
    run_line(12, 1, 1'b0, ""); idle(10, 1'b0);
    run_line(6, 2, 1'b0, "");  idle(10, 1'b0);
    run_line(1, 3, 1'b0, "");  idle(10, 1'b0);
    run_line(2, 3, 1'b0, "");  idle(10, 1'b0);
    // R8: back-to-back lines including a one-pair line
    run_line(5, 3, 1'b0, "R8");
    run_line(1, 3, 1'b0, "R8");
    run_line(3, 3, 1'b0, "R8");
    idle(10, 1'b1);
    // R10: idle beats carry random data and flags
    run_line(10, 3, 1'b1, "R10");
    run_line(7, 3, 1'b1, "R10");
    idle(10, 1'b1);
    run_line(64, 3, 1'b0, "");
    run_line(9, 3, 1'b0, "");
    run_line(4, 3, 1'b1, "");
    idle(40, 1'b1);
    chk_bit("R7 outputs outstanding", q_lo.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule